// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit control registers behind a simple synchronous bus port. Each access names one 32-bit word by its index (byte offset divided by four) inside a 4 KiB window, so only aligned word accesses exist. Read data and an error flag come back on the next clock edge. A protection key register at word 0 guards a fixed range of low offsets. Until the correct key constant has been written there, writes into that range are dropped. Offsets from 0x104 upward stay writable at all times.

Several offsets have behaviour of their own. Some are read-only. One is write-only and reads back as zero. One data offset returns a new pseudo-random word on every read. A strap register is loaded from input pins at reset. On the newer silicon family, that strap register is set bit by bit through its own offset and cleared bit by bit through the revision offset. The revision, both strap words and the initial key state are taken from input pins at reset. All other registers reset from a parameter table.

Top module: `keylock_regbank`

## Requirements
- R1: A write to offset 0x00 (index 0) stores 1 when the data equals the parameter UNLOCK_KEY (default 0x1688A8A8) and 0 otherwise. A read of index 0 returns that 0 or 1. The value changes only through such a write or through reset.
- R2: While the key reads 0, a write to any index from 1 to 64 (offsets 0x04 to 0x100) leaves the bank unchanged and raises the error flag. Index 65 (offset 0x104) and above stay writable while the key reads 0.
- R3: An index at or above NREGS (default 106) reads 0 and raises the error flag. A write to such an index changes nothing and raises the error flag.
- R4: Every read of index 30 (offset 0x78) advances a 32-bit LFSR and returns its new state. The contents of index 29 (offset 0x74) have no effect on this. The LFSR shifts right, and when the bit shifted out is 1 the new state is XORed with 0x80200003. It starts from RNG_SEED (default 0xACE12345) at reset.
- R5: The following indices are read-only: 5 (0x14), 20 to 27 (0x50 to 0x6C), 30 (0x78), 56 (0xE0) and 57 (0xE4). A write to any of them is dropped and raises the error flag.
- R6: On the newer family, an unlocked write to index 28 (offset 0x70) ORs the data into the strap word. An unlocked write to index 31 (offset 0x7C) clears the strap bits set in the data, and the revision word itself does not change. The newer family is the one whose revision bits [31:24] equal NEW_FAMILY_TAG (default 0x04).
- R7: On any other family, an unlocked write to index 28 stores the data as it is. A write to index 31 is dropped and raises the error flag.
- R8: Reset loads the default table, in which index 1 = 0x000000FF, index 16 = 0x000000C0, index 29 = 0x0000000E, indices 56 and 57 = 0x000000FF, and every other index = 0. The pins then override four entries: index 31 takes rev_pins, index 28 takes strap1_pins, index 52 (0xD0) takes strap2_pins and index 0 takes key_boot. After reset, bus_rdata and bus_err are 0.
- R9: Index 48 (offset 0xC0) is write-only. Writes to it are accepted without error, and reads of it return 0 without error.
- R10: bus_rdata and bus_err are valid one cycle after the access. bus_err is high only in the cycle after an access and only for one cycle per access. bus_rdata holds its last value through write cycles and idle cycles.
- R11: Any other in-range index stores the full written word when the write is allowed, and returns that word on a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rev_pins | input | 32 | Silicon revision value loaded at reset |
| strap1_pins | input | 32 | Strap word 1 loaded at reset |
| strap2_pins | input | 32 | Strap word 2 loaded at reset |
| key_boot | input | 1 | Initial key state loaded at reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read |
| bus_err | output | 1 | Error pulse, one cycle after a faulty access |

## Verification
Every result of an access appears at the first clock edge after the access is presented: the register update, the read word, the error pulse and the LFSR step. The bench presents each access on a falling edge and withdraws it on the next falling edge. It samples bus_rdata and bus_err at that second falling edge, after the one rising edge that produces them. A following read then shows any register change. Because the bench also expects bus_rdata to keep its previous value after a write, any cycle slip in the read path appears as a mismatch.

// File: rtl/regbank_pkg.sv
// Package: shared constants, access-kind types and the default reset table
// for the key-locked register bank. Word indices are byte offset / 4.
package regbank_pkg;

    localparam int DEF_REGS    = 106;
    localparam int IDX_KEY     = 0;
    localparam int LOCK_END    = 65;   // first index that ignores the lock
    localparam int IDX_RNGCTL  = 29;
    localparam int IDX_RNG     = 30;
    localparam int IDX_STRAP1  = 28;
    localparam int IDX_REV     = 31;
    localparam int IDX_WONLY   = 48;
    localparam int IDX_STRAP2  = 52;
    localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

    typedef enum logic [2:0] {
        WA_NONE, WA_KEY, WA_PLAIN, WA_STRAP_OR, WA_STRAP_CLR
    } wr_act_e;

    typedef enum logic [1:0] {
        RS_REG, RS_ZERO, RS_RNG
    } rd_src_e;

    // Indices whose contents software may not change.
    function automatic logic is_read_only(input int unsigned ix);
        return (ix == 5) || (ix >= 20 && ix <= 27) || (ix == IDX_RNG)
            || (ix == 56) || (ix == 57);
    endfunction

    // Default table; pin-loaded entries are overridden at reset.
    function automatic logic [DEF_REGS-1:0][31:0] default_table();
        logic [DEF_REGS-1:0][31:0] t;
        t = '0;
        t[1]          = 32'h0000_00FF;
        t[16]         = 32'h0000_00C0;
        t[IDX_RNGCTL] = 32'h0000_000E;
        t[56]         = 32'h0000_00FF;
        t[57]         = 32'h0000_00FF;
        return t;
    endfunction

endpackage

// File: rtl/regbank_lfsr.sv
// Module: 32-bit Galois LFSR used as the random-data source.
// Assumes SEED is nonzero; advances one step per cycle when 'advance' is high.
module regbank_lfsr
    import regbank_pkg::*;
#(
    parameter logic [31:0] SEED = 32'hACE1_2345
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        advance,
    output logic [31:0] state,
    output logic [31:0] next_word
);

    // Next state: right shift, fold taps in when the leaving bit is 1.
    always_comb begin
        next_word = {1'b0, state[31:1]} ^ (state[0] ? LFSR_TAPS : 32'h0);
    end

    // State register, seeded at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (advance) begin
            state <= next_word;
        end
    end

endmodule

// File: rtl/regbank_decode.sv
// Module: classifies one bus access into a write action, a read source and
// an error flag. Purely combinational; priority is range, key, lock, then
// per-offset rules.
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int AW    = 10,
    parameter int NREGS = DEF_REGS
) (
    input  logic [AW-1:0] idx,
    input  logic          we,
    input  logic          unlocked,
    input  logic          new_family,
    output wr_act_e       wr_act,
    output rd_src_e       rd_src,
    output logic          flag_err
);

    int unsigned ix;

    // Decide what the access does to the bank and the read path.
    always_comb begin
        ix       = 32'(idx);
        wr_act   = WA_NONE;
        rd_src   = RS_REG;
        flag_err = 1'b0;
        if (ix >= NREGS) begin
            rd_src   = RS_ZERO;
            flag_err = 1'b1;
        end else if (we) begin
            if (ix == IDX_KEY) begin
                wr_act = WA_KEY;
            end else if (!unlocked && ix < LOCK_END) begin
                flag_err = 1'b1;
            end else if (is_read_only(ix)) begin
                flag_err = 1'b1;
            end else if (ix == IDX_STRAP1) begin
                wr_act = new_family ? WA_STRAP_OR : WA_PLAIN;
            end else if (ix == IDX_REV) begin
                if (new_family) wr_act = WA_STRAP_CLR;
                else            flag_err = 1'b1;
            end else begin
                wr_act = WA_PLAIN;
            end
        end else begin
            if (ix == IDX_RNG)        rd_src = RS_RNG;
            else if (ix == IDX_WONLY) rd_src = RS_ZERO;
        end
    end

endmodule

// File: rtl/keylock_regbank.sv
// Module: key-locked control register bank (top). Holds NREGS 32-bit words,
// answers reads and error status one cycle after the access.
// Assumes: word-aligned 32-bit accesses only, NREGS <= 2**AW.
module keylock_regbank
    import regbank_pkg::*;
#(
    parameter int          NREGS          = DEF_REGS,
    parameter int          WINDOW_BYTES   = 4096,
    parameter logic [31:0] UNLOCK_KEY     = 32'h1688_A8A8,
    parameter logic [7:0]  NEW_FAMILY_TAG = 8'h04,
    parameter logic [31:0] RNG_SEED       = 32'hACE1_2345,
    parameter logic [NREGS-1:0][31:0] RESET_TABLE = default_table(),
    localparam int         AW             = $clog2(WINDOW_BYTES / 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   rev_pins,
    input  logic [31:0]   strap1_pins,
    input  logic [31:0]   strap2_pins,
    input  logic          key_boot,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_err
);

    localparam int IW = $clog2(NREGS);

    logic [31:0]   regs [NREGS];
    logic [IW-1:0] widx;
    logic          unlocked;
    logic          new_family;
    wr_act_e       wr_act;
    rd_src_e       rd_src;
    logic          flag_err;
    logic          rng_adv;
    logic [31:0]   rng_state;
    logic [31:0]   rng_next;

    // Derived control state from stored words.
    always_comb begin
        widx       = bus_addr[IW-1:0];
        unlocked   = regs[IDX_KEY][0];
        new_family = (regs[IDX_REV][31:24] == NEW_FAMILY_TAG);
        rng_adv    = bus_sel && !bus_we && (rd_src == RS_RNG);
    end

    regbank_decode #(
        .AW    (AW),
        .NREGS (NREGS)
    ) u_decode (
        .idx        (bus_addr),
        .we         (bus_we),
        .unlocked   (unlocked),
        .new_family (new_family),
        .wr_act     (wr_act),
        .rd_src     (rd_src),
        .flag_err   (flag_err)
    );

    regbank_lfsr #(
        .SEED (RNG_SEED)
    ) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (rng_adv),
        .state     (rng_state),
        .next_word (rng_next)
    );

    // Register storage: reset load with pin overrides, then decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= RESET_TABLE[i];
            end
            regs[IDX_REV]    <= rev_pins;
            regs[IDX_STRAP1] <= strap1_pins;
            regs[IDX_STRAP2] <= strap2_pins;
            regs[IDX_KEY]    <= {31'b0, key_boot};
        end else if (bus_sel && bus_we) begin
            case (wr_act)
                WA_KEY:       regs[IDX_KEY]    <= {31'b0, (bus_wdata == UNLOCK_KEY)};
                WA_PLAIN:     regs[widx]       <= bus_wdata;
                WA_STRAP_OR:  regs[IDX_STRAP1] <= regs[IDX_STRAP1] | bus_wdata;
                WA_STRAP_CLR: regs[IDX_STRAP1] <= regs[IDX_STRAP1] & ~bus_wdata;
                default:      ;
            endcase
        end
    end

    // Response path: registered read data and one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bus_sel && flag_err;
            if (bus_sel && !bus_we) begin
                case (rd_src)
                    RS_ZERO: bus_rdata <= '0;
                    RS_RNG:  bus_rdata <= rng_next;
                    default: bus_rdata <= regs[widx];
                endcase
            end
        end
    end

endmodule

// File: rtl/keylock_regbank_chk.sv
// Module: assertion checker for keylock_regbank, attached by bind below.
// Assumes reset is held for at least two cycles.
module keylock_regbank_chk
    import regbank_pkg::*;
#(
    parameter int AW    = 10,
    parameter int NREGS = DEF_REGS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_rdata,
    input logic          bus_err,
    input logic [31:0]   key_word,
    input logic [31:0]   rev_word,
    input logic [31:0]   lfsr_word
);

    // R10
    err_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));

    // R3
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && 32'(bus_addr) >= NREGS) |=> (bus_rdata == 32'h0 && bus_err));

    // R2
    locked_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && key_word == 32'h0 && bus_addr != '0
         && 32'(bus_addr) < LOCK_END) |=> bus_err);

    // R1
    key_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_word) |-> $past(bus_sel && bus_we && bus_addr == '0));

    // R4
    rng_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && 32'(bus_addr) == IDX_RNG)
        |=> (!$stable(lfsr_word) && bus_rdata == lfsr_word));

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_word != 32'h0);

    // R6
    rev_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(rev_word));

endmodule

bind keylock_regbank keylock_regbank_chk #(
    .AW    (AW),
    .NREGS (NREGS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .key_word  (regs[0]),
    .rev_word  (regs[31]),
    .lfsr_word (rng_state)
);

// File: tb/keylock_regbank_bench.sv
// Bench: directed corner cases plus seeded random accesses, checked against
// a behavioural model built from the requirements.
module keylock_regbank_bench;

    localparam int          NR   = 106;
    localparam logic [31:0] KEY  = 32'h1688_A8A8;
    localparam logic [31:0] SEED = 32'hACE1_2345;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rev_pins = '0, strap1_pins = '0, strap2_pins = '0;
    logic        key_boot = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] m [NR];
    logic [31:0] mlfsr;
    logic [31:0] last_rd;

    always #5 clk = ~clk;

    keylock_regbank u_keylock_regbank (
        .clk (clk), .rst_n (rst_n),
        .rev_pins (rev_pins), .strap1_pins (strap1_pins),
        .strap2_pins (strap2_pins), .key_boot (key_boot),
        .bus_sel (bus_sel), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_err (bus_err)
    );

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    function automatic bit ro_idx(input int ix);
        return ix == 5 || (ix >= 20 && ix <= 27) || ix == 30 || ix == 56 || ix == 57;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] rv, input logic [31:0] s1,
                            input logic [31:0] s2, input logic kb);
        @(negedge clk);
        rst_n = 1'b0; rev_pins = rv; strap1_pins = s1; strap2_pins = s2; key_boot = kb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) m[i] = 32'h0;
        m[1] = 32'hFF; m[16] = 32'hC0; m[29] = 32'h0E; m[56] = 32'hFF; m[57] = 32'hFF;
        m[31] = rv; m[28] = s1; m[52] = s2; m[0] = {31'b0, kb};
        mlfsr = SEED;
        last_rd = 32'h0;
        // R8: outputs are clear after reset
        check(bus_rdata == 32'h0, "R8 rdata", bus_rdata, 32'h0);
        check(bus_err == 1'b0, "R8 err", {31'b0, bus_err}, 32'h0);
    endtask

    // One access; the model predicts the error flag and read data.
    task automatic access(input logic we, input int ix, input logic [31:0] d,
                          input string req);
        logic        e_err;
        logic [31:0] e_rd;
        bit          newfam;
        newfam = (m[31][31:24] == 8'h04);
        e_err = 1'b0;
        e_rd  = last_rd;
        if (ix >= NR) begin
            e_err = 1'b1;
            if (!we) e_rd = 32'h0;
        end else if (we) begin
            if (ix == 0) m[0] = (d == KEY) ? 32'h1 : 32'h0;
            else if (m[0] == 32'h0 && ix < 65) e_err = 1'b1;
            else if (ro_idx(ix)) e_err = 1'b1;
            else if (ix == 28) m[28] = newfam ? (m[28] | d) : d;
            else if (ix == 31) begin
                if (newfam) m[28] = m[28] & ~d;
                else        e_err = 1'b1;
            end else m[ix] = d;
        end else begin
            if (ix == 30) begin
                mlfsr = lfsr_step(mlfsr);
                e_rd  = mlfsr;
            end else if (ix == 48) e_rd = 32'h0;
            else e_rd = m[ix];
        end
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = 10'(ix); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        check(bus_err == e_err, {req, " err"}, {31'b0, bus_err}, {31'b0, e_err});
        check(bus_rdata == e_rd, {req, " rdata"}, bus_rdata, e_rd);
        last_rd = e_rd;
    endtask

    initial begin
        void'($urandom(32'd4711));
        // Old family, key absent at boot
        do_reset(32'h0201_0303, 32'h0000_1234, 32'h5555_0000, 1'b0);
        access(0, 0,  0, "R8 key boot");
        access(0, 31, 0, "R8 rev pins");
        access(0, 28, 0, "R8 strap1 pins");
        access(0, 52, 0, "R8 strap2 pins");
        access(0, 1,  0, "R8 table idx1");
        access(0, 29, 0, "R8 table idx29");
        access(0, 57, 0, "R8 table idx57");
        access(1, 2,  32'hDEAD_BEEF, "R2 locked write");
        access(0, 2,  0, "R2 locked unchanged");
        access(1, 64, 32'h1111_2222, "R2 locked edge 0x100");
        access(0, 64, 0, "R2 edge unchanged");
        access(1, 65, 32'h3333_4444, "R2 open 0x104");
        access(0, 65, 0, "R2 open readback");
        access(1, 0,  KEY ^ 32'h1, "R1 wrong key");
        access(0, 0,  0, "R1 still locked");
        access(1, 0,  KEY, "R1 right key");
        access(0, 0,  0, "R1 unlocked");
        access(1, 2,  32'hCAFE_F00D, "R11 plain write");
        access(0, 2,  0, "R11 readback");
        access(1, 5,  32'h1, "R5 ro 0x14");
        access(1, 20, 32'h2, "R5 ro 0x50");
        access(1, 27, 32'h3, "R5 ro 0x6C");
        access(1, 30, 32'h4, "R5 ro 0x78");
        access(1, 56, 32'h5, "R5 ro 0xE0");
        access(1, 57, 32'h6, "R5 ro 0xE4");
        access(0, 27, 0, "R5 ro unchanged");
        access(0, 56, 0, "R5 ro unchanged");
        access(1, 28, 32'h00AB_0000, "R7 strap store");
        access(0, 28, 0, "R7 strap readback");
        access(1, 31, 32'hFFFF_FFFF, "R7 rev write drop");
        access(0, 31, 0, "R7 rev unchanged");
        access(0, 30, 0, "R4 rng 1");
        access(0, 30, 0, "R4 rng 2");
        access(1, 29, 32'h0, "R4 ctrl off");
        access(0, 30, 0, "R4 rng ctrl off");
        access(1, 3,  32'h7, "R10 rdata hold on write");
        access(0, NR, 0, "R3 oob read");
        access(0, 1023, 0, "R3 oob top");
        access(1, 200, 32'h9, "R3 oob write");
        access(1, 48, 32'h1234_5678, "R9 wonly write");
        access(0, 48, 0, "R9 wonly read");
        access(1, 0,  32'h0, "R1 relock");
        access(1, 2,  32'h0, "R2 relocked write");
        access(0, 2,  0, "R2 relocked unchanged");

        // Newer family, key present at boot
        do_reset(32'h0403_0303, 32'h0000_F00F, 32'h0, 1'b1);
        access(0, 0,  0, "R8 key boot set");
        access(1, 28, 32'h00F0_0000, "R6 strap or");
        access(0, 28, 0, "R6 strap or readback");
        access(1, 31, 32'h0000_000F, "R6 strap clear");
        access(0, 28, 0, "R6 strap clear readback");
        access(0, 31, 0, "R6 rev unchanged");
        access(0, 30, 0, "R4 rng after reset");

        // Seeded random traffic
        for (int n = 0; n < 600; n++) begin
            int          ix;
            logic        we;
            logic [31:0] d;
            we = 1'($urandom);
            d  = $urandom;
            ix = int'($urandom % 120);
            if ($urandom % 16 == 0) ix = int'($urandom % 1024);
            if (we && $urandom % 8 == 0) begin
                ix = 0;
                if ($urandom % 2 == 0) d = KEY;
            end
            access(we, ix, d, "R11 random");
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule